// File: doc/BRIEF.md
# Video Line Active-Region Rotator

The block receives an 8-bit component video byte stream with embedded timing codes, one byte per clock. Each line is an end-of-active code, a run of blanking bytes, a start-of-active code and then a fixed-length active payload. The block scrambles every line by circularly rotating its active payload by a pseudo-random amount. Timing codes and blanking leave the block unchanged, one clock after they enter, so a downstream receiver still locks to the stream.

Active bytes are written into one half of a two-bank line store while the other half, holding the previous line, is read out rotated. The active payload therefore appears one line late, in the active slot of the following line. Before any complete line has been stored, the active slot is filled with the blanking pair. A 9-bit shift-register sequence steps once per line and is scaled into an offset that is always a multiple of four. This keeps each chroma/luma sample group intact after rotation.

Top module: `video_line_rotator`

## Requirements
- R1: During and directly after a synchronous active-high `rst`, `dout` is 0x00, and the offset sequence register holds `seed`.
- R2: Every byte outside an active region (timing codes and blanking) appears on `dout` unchanged exactly one clock after it is on `din`.
- R3: A start-of-active code is the four-byte run 0xFF, 0x00, 0x00, XY with XY bit 4 = 0. The ACTIVE_LEN (1440) bytes that follow it form the active region. A run with XY bit 4 = 1 (end-of-active code) starts no active region.
- R4: While no complete line has been stored since reset, active byte k is output as 0x80 for even k and 0x10 for odd k, one clock late.
- R5: Once a line P has been stored, active byte k of the next line is output as P[(off_P + k) mod ACTIVE_LEN], one clock late. The last byte of the slot is therefore P[off_P - 1] when off_P > 0.
- R6: The offset of a line equals floor(s × 719 / 1024) × 4, where s is the 9-bit sequence value after that line's step. It is always a multiple of 4 and below 1440.
- R7: The sequence register shifts left by one with new bit 0 = bit 8 XOR bit 3. It steps exactly once per start-of-active code and holds otherwise.
- R8: The offset latched at a line's start-of-active code is used for the whole readout of that line, regardless of later steps.
- R9: Bytes inside an active region, even the run 0xFF, 0x00, 0x00, 0x00, are never taken as timing codes: they neither restart the region nor step the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one byte per cycle |
| rst | input | 1 | Synchronous reset, active high; loads the seed |
| seed | input | 9 | Starting value of the offset sequence |
| din | input | 8 | Incoming video byte stream |
| dout | output | 8 | Outgoing stream, one clock late, active payload rotated and one line late |

## Verification
On every cycle the assertions check several properties. The sequence register moves only on a detected start code. Latched and applied offsets are multiples of four inside the line. The write index stays inside the line, and an active region opens only after a start code and never after an end code. The buffer path is selected only once a full line is stored. The bench's scenarios alone can show that the rotated bytes are the right ones: the first and last bytes of each slot, the wrap point, the fill pattern before the first line, the exact offset sequence after a reseed, and the immunity to code-like data inside the payload.

// File: rtl/vlr_pkg.sv
package vlr_pkg;
  localparam int SEQ_W   = 9;
  localparam int TAP_HI  = 8;
  localparam int TAP_LO  = 3;
  localparam int SCALE   = 719;
  localparam int SCALE_W = 10;
  localparam int PROD_W  = SEQ_W + SCALE_W;
  localparam int OFF_W   = SEQ_W + 2;
  localparam logic [7:0] FILL_EVEN = 8'h80;
  localparam logic [7:0] FILL_ODD  = 8'h10;

  function automatic logic [SEQ_W-1:0] seq_step(input logic [SEQ_W-1:0] s);
    return {s[SEQ_W-2:0], s[TAP_HI] ^ s[TAP_LO]};
  endfunction

  function automatic logic [OFF_W-1:0] seq_to_offset(input logic [SEQ_W-1:0] s);
    logic [PROD_W-1:0] prod;
    prod = PROD_W'(s) * PROD_W'(SCALE);
    return {prod[PROD_W-1 -: SEQ_W], 2'b00};
  endfunction

  function automatic int unsigned wrap_index(input int unsigned off,
                                             input int unsigned k,
                                             input int unsigned len);
    int unsigned s;
    s = off + k;
    return (s >= len) ? s - len : s;
  endfunction
endpackage

// File: rtl/vlr_code_detect.sv
module vlr_code_detect (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic [7:0] din,
  output logic       start_hit,
  output logic       end_hit
);
  logic [7:0] hist [3];
  logic       prefix_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) hist[i] <= 8'h00;
    end else begin
      hist[0] <= din;
      hist[1] <= hist[0];
      hist[2] <= hist[1];
    end
  end

  assign prefix_ok = (hist[2] == 8'hFF) && (hist[1] == 8'h00) && (hist[0] == 8'h00);
  assign start_hit = enable && prefix_ok && !din[4];
  assign end_hit   = enable && prefix_ok &&  din[4];
endmodule

// File: rtl/vlr_offset_gen.sv
module vlr_offset_gen
  import vlr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEQ_W-1:0] seed,
  input  logic             step,
  output logic [OFF_W-1:0] line_off
);
  logic [SEQ_W-1:0] seq_q;
  logic [SEQ_W-1:0] seq_nx;

  assign seq_nx = seq_step(seq_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q    <= seed;
      line_off <= '0;
    end else if (step) begin
      seq_q    <= seq_nx;
      line_off <= seq_to_offset(seq_nx);
    end
  end

  // R7
  seq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(seq_q));

  // R6
  off_align_chk: assert property (@(posedge clk) disable iff (rst)
    line_off[1:0] == 2'b00);
endmodule

// File: rtl/vlr_line_store.sv
module vlr_line_store #(
  parameter int DEPTH = 1440,
  parameter int BANKS = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int BW = $clog2(BANKS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [BW-1:0] wsel,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [BW-1:0] rsel,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] bank_q [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [7:0] cells [DEPTH];
    always_ff @(posedge clk) begin
      if (we && (wsel == BW'(b))) cells[waddr] <= wdata;
    end
    assign bank_q[b] = cells[raddr];
  end

  always_ff @(posedge clk) rdata <= bank_q[rsel];
endmodule

// File: rtl/video_line_rotator.sv
module video_line_rotator
  import vlr_pkg::*;
#(
  parameter int ACTIVE_LEN = 1440
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEQ_W-1:0] seed,
  input  logic [7:0]       din,
  output logic [7:0]       dout
);
  localparam int AW = $clog2(ACTIVE_LEN);

  logic             start_hit, end_hit;
  logic [OFF_W-1:0] line_off;
  logic [OFF_W-1:0] rd_off;
  logic             in_act;
  logic [AW-1:0]    wr_idx;
  logic             wbank;
  logic             have_line;
  logic             use_store_q;
  logic [7:0]       byte_q;
  logic [7:0]       store_q;
  logic [AW-1:0]    rd_addr;
  logic             last_byte;

  vlr_code_detect u_detect (
    .clk(clk), .rst(rst), .enable(!in_act), .din(din),
    .start_hit(start_hit), .end_hit(end_hit)
  );

  vlr_offset_gen u_offset (
    .clk(clk), .rst(rst), .seed(seed), .step(start_hit), .line_off(line_off)
  );

  assign rd_addr   = AW'(wrap_index(int'(rd_off), int'(wr_idx), ACTIVE_LEN));
  assign last_byte = (wr_idx == AW'(ACTIVE_LEN - 1));

  vlr_line_store #(.DEPTH(ACTIVE_LEN), .BANKS(2)) u_store (
    .clk(clk), .we(in_act), .wsel(wbank), .waddr(wr_idx), .wdata(din),
    .rsel(!wbank), .raddr(rd_addr), .rdata(store_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      in_act      <= 1'b0;
      wr_idx      <= '0;
      wbank       <= 1'b0;
      have_line   <= 1'b0;
      rd_off      <= '0;
      use_store_q <= 1'b0;
      byte_q      <= 8'h00;
    end else begin
      use_store_q <= in_act && have_line;
      if (in_act) byte_q <= wr_idx[0] ? FILL_ODD : FILL_EVEN;
      else        byte_q <= din;
      if (in_act) begin
        if (last_byte) begin
          in_act    <= 1'b0;
          wr_idx    <= '0;
          wbank     <= !wbank;
          have_line <= 1'b1;
          rd_off    <= line_off;
        end else begin
          wr_idx <= wr_idx + 1'b1;
        end
      end else if (start_hit) begin
        in_act <= 1'b1;
        wr_idx <= '0;
      end
    end
  end

  assign dout = use_store_q ? store_q : byte_q;

  // R3
  act_open_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(in_act) |-> ($past(start_hit) && wr_idx == '0));

  // R3
  end_code_chk: assert property (@(posedge clk) disable iff (rst)
    end_hit |=> !in_act);

  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    in_act |-> (int'(wr_idx) < ACTIVE_LEN));

  // R5
  store_ready_chk: assert property (@(posedge clk) disable iff (rst)
    use_store_q |-> have_line);

  // R6
  rd_off_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_off[1:0] == 2'b00) && (int'(rd_off) < ACTIVE_LEN));

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (in_act && !last_byte) |=> (in_act && wr_idx == $past(wr_idx) + 1'b1));
endmodule

// File: tb/video_line_rotator_bench.sv
`timescale 1ns/1ps
module video_line_rotator_bench;
  localparam int L  = 1440;
  localparam int BL = 20;

  logic       clk = 0;
  logic       rst = 1;
  logic [8:0] seed = 9'h1A5;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [8:0] seq_m;
  logic [7:0] prev_line [L];
  logic [7:0] cur_line  [L];
  int         prev_off;
  bit         have_prev;
  logic [7:0] obs;

  always #5 clk = ~clk;

  video_line_rotator u_video_line_rotator (
    .clk(clk), .rst(rst), .seed(seed), .din(din), .dout(dout)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    din = b;
    @(posedge clk);
    #1 obs = dout;
  endtask

  function automatic logic [8:0] model_next(input logic [8:0] s);
    logic fb;
    fb = s[8] ^ s[3];
    return (s << 1) | 9'(fb);
  endfunction

  function automatic int model_off(input logic [8:0] s);
    return ((int'(s) * 719) / 1024) * 4;
  endfunction

  task automatic do_reset(input logic [8:0] sd);
    @(negedge clk);
    rst = 1; seed = sd; din = 8'h00;
    repeat (3) @(posedge clk);
    #1 chk(dout == 8'h00, "R1 dout during reset", dout, 0);
    @(negedge clk);
    rst = 0;
    seq_m = sd;
    have_prev = 0;
    prev_off = 0;
    #1 chk(dout == 8'h00, "R1 dout after reset", dout, 0);
  endtask

  task automatic send_line(input int id, input bit inject, input string tag);
    int pass_bad = 0, pass_act = 0, pass_exp = 0;
    int act_bad = 0, act_act = 0, act_exp = 0;
    int first_obs = 0, last_obs = 0, off;
    logic [7:0] b, e;
    logic [7:0] eav [4];
    logic [7:0] sav [4];
    eav = '{8'hFF, 8'h00, 8'h00, 8'h9D};
    sav = '{8'hFF, 8'h00, 8'h00, 8'h80};
    for (int i = 0; i < 4; i++) begin
      put(eav[i]);
      if (obs != eav[i]) begin pass_bad++; pass_act = obs; pass_exp = eav[i]; end
    end
    for (int i = 0; i < BL; i++) begin
      b = i[0] ? 8'h10 : 8'h80;
      put(b);
      if (obs != b) begin pass_bad++; pass_act = obs; pass_exp = b; end
    end
    for (int i = 0; i < 4; i++) begin
      put(sav[i]);
      if (obs != sav[i]) begin pass_bad++; pass_act = obs; pass_exp = sav[i]; end
    end
    seq_m = model_next(seq_m);
    off = model_off(seq_m);
    for (int k = 0; k < L; k++) begin
      b = 8'((id * 29) + (k * 7) + (k >> 5));
      if (inject && k == 200) b = 8'hFF;
      if (inject && (k == 201 || k == 202 || k == 203)) b = 8'h00;
      cur_line[k] = b;
      if (have_prev) e = prev_line[(prev_off + k) % L];
      else           e = k[0] ? 8'h10 : 8'h80;
      put(b);
      if (k == 0) first_obs = obs;
      if (k == L - 1) last_obs = obs;
      if (obs != e) begin act_bad++; act_act = obs; act_exp = e; end
    end
    chk(pass_bad == 0, {tag, " R2 R3 codes and blanking pass"}, pass_act, pass_exp);
    if (have_prev) begin
      chk(act_bad == 0, {tag, " R5 rotated slot"}, act_act, act_exp);
      chk(first_obs == prev_line[prev_off], {tag, " R6 first byte at offset"},
          first_obs, prev_line[prev_off]);
      chk(last_obs == prev_line[(prev_off + L - 1) % L], {tag, " R5 wrap last byte"},
          last_obs, prev_line[(prev_off + L - 1) % L]);
    end else begin
      chk(act_bad == 0, {tag, " R4 fill before first line"}, act_act, act_exp);
    end
    for (int k = 0; k < L; k++) prev_line[k] = cur_line[k];
    prev_off = off;
    have_prev = 1;
  endtask

  task automatic t_reset_state();
    do_reset(9'h1A5);
  endtask

  task automatic t_first_line();
    send_line(1, 0, "R4 first line");
  endtask

  task automatic t_rotation_run();
    send_line(2, 0, "R5 line2");
    send_line(3, 0, "R7 R8 line3");
    send_line(4, 1, "R9 line4 code-like data");
    send_line(5, 0, "R9 line5 after injected line");
  endtask

  task automatic t_reseed();
    do_reset(9'h0F3);
    send_line(6, 0, "R1 R4 reseed first line");
    send_line(7, 0, "R7 reseed line2");
    chk(model_off(9'h1FF) == 1432, "R6 max offset below line", model_off(9'h1FF), 1432);
  endtask

  initial begin
    t_reset_state();
    t_first_line();
    t_rotation_run();
    t_reseed();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule